// File: doc/BRIEF.md
# Next-Block and Live-Time Correlation Predictor

This block is a set-associative correlation table that sits beside a level-one data cache and learns, frame by frame, which block tends to follow which. The history for a frame is a pair of tags: the block that lived there before (older) and the block that lives there now (newer). For each history it learns two things: the tag of the block that came next, and how long the newer block stayed live before it was replaced. A prefetcher can use the predicted tag to pick what to fetch into the frame. It can use the predicted live time to decide when to issue that fetch.

The table has two ports that both work in one cycle. On an eviction, the update port records what was seen. When block B replaces A in a frame that held D before A, the controller presents the history (D, A), the successor B and the live time measured for A. On the new fill, the lookup port is presented with the history (A, B) and returns a prediction for B one cycle later. The low bits of the prefetch address are not stored, because they are always the index of the frame itself.

The set is chosen by two fields. The upper field is the low bits of the sum of the two history tags. The lower field is the low bit or bits of the frame index. Inside the set, only the newer tag is kept as the identifier.

Top module: `corr_table`

## Requirements
- R1: After synchronous reset, every entry is invalid. `pred_valid` is 0 during reset, and every lookup made afterwards misses until an update has written the history it asks for.
- R2: The set number is {(older + newer) mod 2^SUM_BITS, frame_index mod 2^CIDX_BITS}, with the sum field in the upper bits. With the defaults (SUM_BITS=7, CIDX_BITS=1) this gives 256 sets of 8 ways.
- R3: A lookup hits when a valid way of its set holds an identifier equal to the lookup's newer tag. The hit returns that way's stored next tag and live time. On a miss, `pred_hit`, `pred_tag` and `pred_live` are all 0.
- R4: An update whose newer tag is already held as an identifier in the set overwrites that way's next tag and live time in place.
- R5: An update with no matching identifier allocates a way. It takes the lowest-numbered invalid way if there is one; otherwise it takes the way updated least recently. Every update makes its way the most recently updated one. Lookups never change contents or recency.
- R6: `pred_valid` is 1 exactly in the cycle after `lk_valid` was 1. The prediction fields are registered at the same edge.
- R7: When an update and a lookup happen in the same cycle, the lookup sees the table as it is after the update. This covers both a value just written and a way just reclaimed.
- R8: The older tag affects only the set number. Two histories with the same newer tag whose sums agree in the low SUM_BITS bits name the same entry.
- R9: Frame index bits above the low CIDX_BITS bits have no effect. The low bit does separate sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Update request this cycle |
| upd_older | input | TAG_W | Older history tag of the update |
| upd_newer | input | TAG_W | Newer history tag (identifier) of the update |
| upd_next | input | TAG_W | Observed successor tag to record |
| upd_live | input | LT_W | Measured live time to record |
| upd_fidx | input | FIDX_W | Frame index of the update |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_older | input | TAG_W | Older history tag of the lookup |
| lk_newer | input | TAG_W | Newer history tag of the lookup |
| lk_fidx | input | FIDX_W | Frame index of the lookup |
| pred_valid | output | 1 | Prediction result present |
| pred_hit | output | 1 | Entry found for the lookup history |
| pred_tag | output | TAG_W | Predicted next tag (0 on miss) |
| pred_live | output | LT_W | Predicted live time (0 on miss) |

## Verification
Suppose recency state is wrong, such as the wrong way picked as least recent or a lookup that disturbs the order. It shows up only when a full set takes one more distinct identifier: a lookup of the history that should have survived then misses, or one that should be gone still hits. So the bench fills a set to nine identifiers, with plain lookups in between, and probes each way right away. A bad set hash or a wrong identifier compare shows up on the very next lookup, as a false hit or a false miss on histories built to alias or to differ by one index bit. A broken same-cycle merge shows up as a stale value in the one cycle where both ports meet.

// File: rtl/ctab_pkg.sv
`timescale 1ns/1ps
package ctab_pkg;
  // default geometry of the correlation table
  localparam int DEF_TAG_W     = 16;
  localparam int DEF_LT_W      = 8;
  localparam int DEF_SUM_BITS  = 7;
  localparam int DEF_CIDX_BITS = 1;
  localparam int DEF_FIDX_W    = 10;
  localparam int DEF_WAYS      = 8;
endpackage

// File: rtl/ctab_index.sv
`timescale 1ns/1ps
module ctab_index #(
  parameter int TAG_W     = 16,
  parameter int SUM_BITS  = 7,
  parameter int CIDX_BITS = 1,
  parameter int FIDX_W    = 10,
  localparam int SET_W    = SUM_BITS + CIDX_BITS
) (
  input  logic [TAG_W-1:0]  older_i,
  input  logic [TAG_W-1:0]  newer_i,
  input  logic [FIDX_W-1:0] fidx_i,
  output logic [SET_W-1:0]  set_o
);
  logic [TAG_W-1:0] sum;
  always_comb begin
    sum   = older_i + newer_i;
    set_o = {sum[SUM_BITS-1:0], fidx_i[CIDX_BITS-1:0]};
  end
endmodule

// File: rtl/ctab_match.sv
`timescale 1ns/1ps
module ctab_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [TAG_W-1:0] ids_i [WAYS],
  input  logic [TAG_W-1:0] key_i,
  output logic [WAYS-1:0]  hit_vec_o,
  output logic             hit_o,
  output logic [WAY_W-1:0] way_o
);
  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign hit_vec_o[g] = valid_i[g] && (ids_i[g] == key_i);
    end
  endgenerate

  always_comb begin
    hit_o = |hit_vec_o;
    way_o = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (hit_vec_o[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ctab_lru.sv
`timescale 1ns/1ps
module ctab_lru #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] age_i [WAYS],
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  output logic [WAY_W-1:0] way_o,
  output logic [WAY_W-1:0] age_o [WAYS],
  output logic [WAYS-1:0]  oldest_vec_o
);
  logic [WAY_W-1:0] inv_way, old_way;
  logic             any_inv;

  always_comb begin
    inv_way = '0;
    old_way = '0;
    any_inv = ~&valid_i;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!valid_i[w]) inv_way = WAY_W'(w);
    end
    for (int w = 0; w < WAYS; w++) begin
      oldest_vec_o[w] = (age_i[w] == WAY_W'(WAYS-1));
      if (oldest_vec_o[w]) old_way = WAY_W'(w);
    end
    if (hit_i)        way_o = hit_way_i;
    else if (any_inv) way_o = inv_way;
    else              way_o = old_way;
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == way_o)            age_o[w] = '0;
      else if (age_i[w] < age_i[way_o])  age_o[w] = age_i[w] + 1'b1;
      else                               age_o[w] = age_i[w];
    end
  end
endmodule

// File: rtl/corr_table.sv
`timescale 1ns/1ps
module corr_table
  import ctab_pkg::*;
#(
  parameter int TAG_W     = DEF_TAG_W,
  parameter int LT_W      = DEF_LT_W,
  parameter int SUM_BITS  = DEF_SUM_BITS,
  parameter int CIDX_BITS = DEF_CIDX_BITS,
  parameter int FIDX_W    = DEF_FIDX_W,
  parameter int WAYS      = DEF_WAYS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [TAG_W-1:0]  upd_older,
  input  logic [TAG_W-1:0]  upd_newer,
  input  logic [TAG_W-1:0]  upd_next,
  input  logic [LT_W-1:0]   upd_live,
  input  logic [FIDX_W-1:0] upd_fidx,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_older,
  input  logic [TAG_W-1:0]  lk_newer,
  input  logic [FIDX_W-1:0] lk_fidx,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic [TAG_W-1:0]  pred_tag,
  output logic [LT_W-1:0]   pred_live
);
  localparam int SET_W = SUM_BITS + CIDX_BITS;
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = $clog2(WAYS);

  // table storage: valid/recency are reset, payload is not
  logic [WAYS-1:0]  v_q   [SETS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [TAG_W-1:0] id_q  [SETS][WAYS];
  logic [TAG_W-1:0] nx_q  [SETS][WAYS];
  logic [LT_W-1:0]  lt_q  [SETS][WAYS];

  logic [SET_W-1:0] u_set, l_set;

  ctab_index #(.TAG_W(TAG_W), .SUM_BITS(SUM_BITS), .CIDX_BITS(CIDX_BITS), .FIDX_W(FIDX_W))
    u_idx_upd (.older_i(upd_older), .newer_i(upd_newer), .fidx_i(upd_fidx), .set_o(u_set));
  ctab_index #(.TAG_W(TAG_W), .SUM_BITS(SUM_BITS), .CIDX_BITS(CIDX_BITS), .FIDX_W(FIDX_W))
    u_idx_lk  (.older_i(lk_older), .newer_i(lk_newer), .fidx_i(lk_fidx), .set_o(l_set));

  // ---------------- update path ----------------
  logic [WAYS-1:0]  u_hvec, u_oldest;
  logic             u_hit;
  logic [WAY_W-1:0] u_hway, u_way;
  logic [WAY_W-1:0] u_age_n [WAYS];

  ctab_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_upd (
    .valid_i(v_q[u_set]), .ids_i(id_q[u_set]), .key_i(upd_newer),
    .hit_vec_o(u_hvec), .hit_o(u_hit), .way_o(u_hway));

  ctab_lru #(.WAYS(WAYS)) u_lru (
    .valid_i(v_q[u_set]), .age_i(age_q[u_set]), .hit_i(u_hit), .hit_way_i(u_hway),
    .way_o(u_way), .age_o(u_age_n), .oldest_vec_o(u_oldest));

  // ---------------- lookup path (sees post-update view) ----------------
  logic [WAYS-1:0]  l_v;
  logic [TAG_W-1:0] l_id [WAYS];
  logic [TAG_W-1:0] l_nx [WAYS];
  logic [LT_W-1:0]  l_lt [WAYS];
  logic             same_set;

  always_comb begin
    same_set = upd_valid && (u_set == l_set);
    for (int w = 0; w < WAYS; w++) begin
      if (same_set && (WAY_W'(w) == u_way)) begin
        l_v[w]  = 1'b1;
        l_id[w] = upd_newer;
        l_nx[w] = upd_next;
        l_lt[w] = upd_live;
      end else begin
        l_v[w]  = v_q[l_set][w];
        l_id[w] = id_q[l_set][w];
        l_nx[w] = nx_q[l_set][w];
        l_lt[w] = lt_q[l_set][w];
      end
    end
  end

  logic [WAYS-1:0]  l_hvec;
  logic             l_hit;
  logic [WAY_W-1:0] l_way;

  ctab_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_lk (
    .valid_i(l_v), .ids_i(l_id), .key_i(lk_newer),
    .hit_vec_o(l_hvec), .hit_o(l_hit), .way_o(l_way));

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (upd_valid) begin
      v_q[u_set][u_way] <= 1'b1;
      for (int w = 0; w < WAYS; w++) age_q[u_set][w] <= u_age_n[w];
    end
  end

  always_ff @(posedge clk) begin
    if (upd_valid) begin
      id_q[u_set][u_way] <= upd_newer;
      nx_q[u_set][u_way] <= upd_next;
      lt_q[u_set][u_way] <= upd_live;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_hit   <= 1'b0;
      pred_tag   <= '0;
      pred_live  <= '0;
    end else begin
      pred_valid <= lk_valid;
      pred_hit   <= lk_valid && l_hit;
      pred_tag   <= (lk_valid && l_hit) ? l_nx[l_way] : '0;
      pred_live  <= (lk_valid && l_hit) ? l_lt[l_way] : '0;
    end
  end

  // ---------------- assertions ----------------
  a_r6_pred_follows_lookup: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid);
  a_r6_pred_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid);
  a_r3_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    pred_hit |-> pred_valid);
  a_r3_miss_fields_zero: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_hit) |-> (pred_tag == '0 && pred_live == '0));
  a_r4_unique_identifier: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> $onehot0(u_hvec));
  a_r5_single_oldest: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> ($countones(u_oldest) == 1));
endmodule

// File: tb/corr_table_tb_top.sv
`timescale 1ns/1ps
module corr_table_tb_top;
  localparam int TAG_W = 16, LT_W = 8, SUM_BITS = 7, CIDX_BITS = 1, FIDX_W = 10, WAYS = 8;
  localparam int SETS = 1 << (SUM_BITS + CIDX_BITS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              upd_valid = 0, lk_valid = 0;
  logic [TAG_W-1:0]  upd_older = 0, upd_newer = 0, upd_next = 0, lk_older = 0, lk_newer = 0;
  logic [LT_W-1:0]   upd_live = 0;
  logic [FIDX_W-1:0] upd_fidx = 0, lk_fidx = 0;
  logic              pred_valid, pred_hit;
  logic [TAG_W-1:0]  pred_tag;
  logic [LT_W-1:0]   pred_live;

  corr_table dut_i (
    .clk(clk), .rst(rst),
    .upd_valid(upd_valid), .upd_older(upd_older), .upd_newer(upd_newer),
    .upd_next(upd_next), .upd_live(upd_live), .upd_fidx(upd_fidx),
    .lk_valid(lk_valid), .lk_older(lk_older), .lk_newer(lk_newer), .lk_fidx(lk_fidx),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_tag(pred_tag), .pred_live(pred_live));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    bit              hit;
    logic [TAG_W-1:0] tag;
    logic [LT_W-1:0]  live;
    string           req;
  } exp_t;
  exp_t expq[$];

  // reference model: per-way valid, id, payload and last-update stamp
  bit               m_v     [SETS][WAYS];
  logic [TAG_W-1:0] m_id    [SETS][WAYS];
  logic [TAG_W-1:0] m_nx    [SETS][WAYS];
  logic [LT_W-1:0]  m_lt    [SETS][WAYS];
  int               m_stamp [SETS][WAYS];
  int               now_stamp = 0;

  function automatic int m_set(logic [TAG_W-1:0] o, logic [TAG_W-1:0] n, logic [FIDX_W-1:0] f);
    logic [TAG_W-1:0] s;
    s = o + n;
    return (int'(s % (1 << SUM_BITS)) << CIDX_BITS) + int'(f % (1 << CIDX_BITS));
  endfunction

  task automatic m_update(logic [TAG_W-1:0] o, n, nx, logic [LT_W-1:0] lt, logic [FIDX_W-1:0] f);
    int s, w;
    s = m_set(o, n, f);
    w = -1;
    for (int k = 0; k < WAYS; k++) if (w < 0 && m_v[s][k] && m_id[s][k] == n) w = k;
    for (int k = 0; k < WAYS; k++) if (w < 0 && !m_v[s][k]) w = k;
    if (w < 0) begin
      w = 0;
      for (int k = 1; k < WAYS; k++) if (m_stamp[s][k] < m_stamp[s][w]) w = k;
    end
    now_stamp++;
    m_v[s][w] = 1; m_id[s][w] = n; m_nx[s][w] = nx; m_lt[s][w] = lt;
    m_stamp[s][w] = now_stamp;
  endtask

  function automatic exp_t m_lookup(logic [TAG_W-1:0] o, n, logic [FIDX_W-1:0] f, string req);
    exp_t e;
    int s;
    s = m_set(o, n, f);
    e.hit = 0; e.tag = '0; e.live = '0; e.req = req;
    for (int k = 0; k < WAYS; k++)
      if (m_v[s][k] && m_id[s][k] == n) begin e.hit = 1; e.tag = m_nx[s][k]; e.live = m_lt[s][k]; end
    return e;
  endfunction

  // driver: one cycle of stimulus; model applies the update before the lookup (R7)
  task automatic step(bit uv, logic [TAG_W-1:0] uo, un, unx, logic [LT_W-1:0] ul, logic [FIDX_W-1:0] uf,
                      bit lv, logic [TAG_W-1:0] lo, ln, logic [FIDX_W-1:0] lf,
                      bit use_hand, bit h_hit, logic [TAG_W-1:0] h_tag, logic [LT_W-1:0] h_live, string req);
    exp_t e;
    @(negedge clk);
    upd_valid = uv; upd_older = uo; upd_newer = un; upd_next = unx; upd_live = ul; upd_fidx = uf;
    lk_valid = lv; lk_older = lo; lk_newer = ln; lk_fidx = lf;
    if (uv) m_update(uo, un, unx, ul, uf);
    if (lv) begin
      if (use_hand) begin e.hit = h_hit; e.tag = h_tag; e.live = h_live; e.req = req; end
      else e = m_lookup(lo, ln, lf, req);
      expq.push_back(e);
    end
  endtask

  task automatic upd(logic [TAG_W-1:0] o, n, nx, logic [LT_W-1:0] lt, logic [FIDX_W-1:0] f);
    step(1, o, n, nx, lt, f, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic look(logic [TAG_W-1:0] o, n, logic [FIDX_W-1:0] f,
                      bit h, logic [TAG_W-1:0] t, logic [LT_W-1:0] lt, string req);
    step(0, 0, 0, 0, 0, 0, 1, o, n, f, 1, h, t, lt, req);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // monitor: sample away from the active edge
  initial begin
    exp_t e;
    wait (!rst);
    forever begin
      @(posedge clk); #2;
      if (pred_valid) begin
        n_chk++;
        if (expq.size() == 0) begin
          n_fail++;
          $display("FAIL R6 unexpected pred_valid actual=1 expected=0");
        end else begin
          e = expq.pop_front();
          if (pred_hit !== e.hit || pred_tag !== e.tag || pred_live !== e.live) begin
            n_fail++;
            $display("FAIL %s actual hit=%0d tag=%h live=%0d expected hit=%0d tag=%h live=%0d",
                     e.req, pred_hit, pred_tag, pred_live, e.hit, e.tag, e.live);
          end
        end
      end
    end
  end

  function automatic logic [TAG_W-1:0] old_for(logic [TAG_W-1:0] n);
    return TAG_W'(16'h0032) - n; // sum of older and newer is 0x32 in the low bits
  endfunction

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin m_v[s][w] = 0; m_stamp[s][w] = 0; end
    // R1: outputs quiet during reset
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if (pred_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1 pred_valid in reset actual=%0d expected=0", pred_valid);
    end
    @(negedge clk); rst = 0;

    // R1: empty table misses
    look(16'h0010, 16'h0020, 0, 0, 0, 0, "R1 empty");
    look(16'h1234, 16'h0001, 1, 0, 0, 0, "R1 empty");

    // R3/R4: write then read, overwrite in place
    upd(16'h0010, 16'h0020, 16'h0030, 8'd37, 0);
    look(16'h0010, 16'h0020, 0, 1, 16'h0030, 8'd37, "R3 basic hit");
    upd(16'h0010, 16'h0020, 16'h0044, 8'd5, 0);
    look(16'h0010, 16'h0020, 0, 1, 16'h0044, 8'd5, "R4 overwrite");

    // R9/R2: low frame index bit separates, upper bits ignored
    look(16'h0010, 16'h0020, 1, 0, 0, 0, "R9 index bit0 separates");
    look(16'h0010, 16'h0020, 10'h3FE, 1, 16'h0044, 8'd5, "R9 upper index bits ignored");

    // R8/R2: older tag only steers the set
    look(16'h0090, 16'h0020, 0, 1, 16'h0044, 8'd5, "R8 older alias same sum");
    look(16'h0011, 16'h0020, 0, 0, 0, 0, "R2 different sum misses");

    // R5: fill one set with 8 identifiers, lookups in between must not alter recency
    for (int k = 0; k < 8; k++)
      upd(old_for(TAG_W'(16'h0100 + k)), TAG_W'(16'h0100 + k), TAG_W'(16'h0200 + k), LT_W'(k + 1), 0);
    for (int k = 0; k < 3; k++)
      look(old_for(16'h0100), 16'h0100, 0, 1, 16'h0200, 8'd1, "R5 lookup before eviction");
    upd(old_for(16'h0108), 16'h0108, 16'h0208, 8'd9, 0);
    look(old_for(16'h0100), 16'h0100, 0, 0, 0, 0, "R5 least recently updated evicted");
    look(old_for(16'h0101), 16'h0101, 0, 1, 16'h0201, 8'd2, "R5 survivor");
    look(old_for(16'h0108), 16'h0108, 0, 1, 16'h0208, 8'd9, "R5 new way");
    upd(old_for(16'h0101), 16'h0101, 16'h0201, 8'd2, 0);
    upd(old_for(16'h0109), 16'h0109, 16'h0209, 8'd10, 0);
    look(old_for(16'h0102), 16'h0102, 0, 0, 0, 0, "R5 refresh moves victim");
    look(old_for(16'h0101), 16'h0101, 0, 1, 16'h0201, 8'd2, "R5 refreshed kept");

    // R7: same-cycle update and lookup
    step(1, old_for(16'h0105), 16'h0105, 16'h03AA, 8'd77, 0,
         1, old_for(16'h0105), 16'h0105, 0, 1, 1, 16'h03AA, 8'd77, "R7 same-cycle write seen");
    step(1, old_for(16'h010A), 16'h010A, 16'h020A, 8'd11, 0,
         1, old_for(16'h0103), 16'h0103, 0, 1, 0, 0, 0, "R7 same-cycle eviction seen");
    look(old_for(16'h0104), 16'h0104, 0, 1, 16'h0204, 8'd5, "R5 other way intact");
    look(old_for(16'h010A), 16'h010A, 0, 1, 16'h020A, 8'd11, "R7 allocated way");
    idle();

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [TAG_W-1:0] a, b, c, d, nx;
      bit uv, lv;
      uv = ($urandom % 3) != 0;
      lv = ($urandom % 3) != 0;
      a = TAG_W'($urandom % 16); b = TAG_W'($urandom % 16);
      c = ($urandom % 2) ? a : TAG_W'($urandom % 16);
      d = ($urandom % 2) ? b : TAG_W'($urandom % 16);
      nx = TAG_W'($urandom);
      step(uv, a, b, nx, LT_W'($urandom), FIDX_W'($urandom),
           lv, c, d, FIDX_W'($urandom), 0, 0, 0, 0, "R3 R4 R5 R7 mixed");
    end
    repeat (3) idle();

    n_chk++;
    if (expq.size() != 0) begin
      n_fail++; $display("FAIL R6 missing predictions actual=%0d expected=0", expq.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule